// File: doc/BRIEF.md
# CAN Physical-Layer Mode and Fault Controller

This block is the digital control core that sits between a CAN protocol controller and the analog parts of a high-speed CAN line interface. It takes a mode-select level, the controller's transmit bit, the bus state seen by a fast receiver and by a low-power receiver, two supply-good flags (core and I/O) and an over-temperature flag. From these it drives four outputs: the bus driver enable, the dominant drive command, the receive bit returned to the controller, and the enable of the mid-supply split-termination reference.

Two watchdogs guard against stuck-dominant faults. In Normal mode, a transmit input held low for too long cuts the bus drivers. In Standby mode, a bus held dominant for too long forces the receive bit recessive. In Standby mode the receive bit comes from the low-power receiver through a wake-up filter, which ignores short dominant glitches. Supply and thermal conditions gate the outputs on top of all this. Every timing value is given in nanoseconds and converted to clock cycles from a clock-frequency parameter. Every input passes through a two-flop synchronizer.

Top module: `can_phy_ctrl`

## Requirements
- R1: While reset is asserted, drv_en_o=0, drv_dom_o=0, rxd_o=1 and split_en_o=0.
- R2: mode_i=0 selects Normal and mode_i=1 selects Standby. In Normal mode with drivers enabled, drv_dom_o equals the inverse of txd_i. Every input reaches the outputs two clock edges after it changes.
- R3: In Normal mode, rxd_o is 0 when hs_dom_i=1 and 1 when hs_dom_i=0. When core_ok_i=0, rxd_o is 1 regardless of hs_dom_i.
- R4: In Standby mode, drv_en_o=0 and split_en_o=0, and hs_dom_i has no effect on rxd_o. rxd_o goes low only after lp_dom_i has been 1 for at least WAKE_CYC consecutive synchronized cycles. A shorter dominant pulse leaves rxd_o high.
- R5: In Normal mode, txd_i held low for TMO_CYC synchronized cycles sets drv_en_o=0. A hold of TMO_CYC-1 cycles does not. The drivers stay off while txd_i stays low, and they come back on after txd_i returns high.
- R6: In Standby mode, lp_dom_i held at 1 for TMO_CYC synchronized cycles forces rxd_o=1 for as long as it stays 1. After a recessive bus is seen, the wake-up filter works again.
- R7: The drivers stay disabled until core_ok_i and io_ok_i have both been 1 at the same time since core_ok_i last fell. A later drop of io_ok_i alone does not disable them, but a drop of core_ok_i does. The low-power receive path in Standby is subject to the same arming condition; while it is not armed, rxd_o=1.
- R8: ot_i=1 sets drv_en_o=0 without affecting rxd_o or split_en_o.
- R9: split_en_o is 1 exactly when the block is in Normal mode and core_ok_i=1.
- R10: A change of mode clears both stuck-dominant timers. After the mode is entered again, a full timeout must elapse before either one trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Mode select: 0 Normal, 1 Standby |
| txd_i | input | 1 | Transmit bit: 0 dominant, 1 recessive |
| hs_dom_i | input | 1 | High-speed receiver reports dominant bus |
| lp_dom_i | input | 1 | Low-power receiver reports dominant bus |
| core_ok_i | input | 1 | Core supply above undervoltage level |
| io_ok_i | input | 1 | I/O supply above undervoltage level |
| ot_i | input | 1 | Over-temperature flag |
| drv_en_o | output | 1 | Bus driver enable (0 = high impedance) |
| drv_dom_o | output | 1 | Drive the bus dominant |
| rxd_o | output | 1 | Receive bit: 0 dominant, 1 recessive |
| split_en_o | output | 1 | Split reference enable (0 = tri-stated) |

## Verification
The bench builds the block with a 50 MHz clock, a 400 ns timeout and a 100 ns wake-up time. This gives a 20-cycle timeout and a 5-cycle wake-up filter. With these short windows, both watchdogs and the filter can be stepped cycle by cycle through their thresholds, including the exact timeout and one cycle on each side. The wake-up filter is also swept over every pulse length up to one past its limit. The small values also make it cheap to sweep all combinations of mode and core supply, and to walk through supply arming, thermal cut-off and re-entry into each mode.

// File: rtl/can_phy_pkg.sv
package can_phy_pkg;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_STANDBY = 1'b1
  } phy_mode_e;

  // Converts a duration in nanoseconds into whole clock cycles.
  function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                            input longint unsigned ns);
    longint unsigned prod;
    prod = (hz * ns) / 64'd1_000_000_000;
    return prod[31:0];
  endfunction

  // Indices of the synchronized input vector.
  localparam int SI_MODE = 0;
  localparam int SI_TXD  = 1;
  localparam int SI_HS   = 2;
  localparam int SI_LP   = 3;
  localparam int SI_CORE = 4;
  localparam int SI_IO   = 5;
  localparam int SI_OT   = 6;
  localparam int SI_NUM  = 7;

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned        W       = 1,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end

    assign q_o[b] = sync_q;
  end

endmodule

// File: rtl/dom_counter.sv
module dom_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic level_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          run;
  logic          cnt_en;

  assign run = active_i & level_i;

  always_comb begin
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q != TOP) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  assign cnt_en = !run || (cnt_q != TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = (cnt_q == TOP);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP) else $error("count above limit"); // R5

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_i && level_i) |=> (cnt_q == '0)) else $error("count not cleared"); // R10

  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && active_i && level_i) |=> hit_o) else $error("trip released early"); // R6

endmodule

// File: rtl/supply_arm.sv
module supply_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic core_ok_i,
  input  logic io_ok_i,
  output logic armed_o
);

  logic armed_q;
  logic armed_d;

  assign armed_d = core_ok_i & (armed_q | io_ok_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ok_i |=> !armed_o) else $error("armed after core loss"); // R7

  AST_ARM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> ($past(io_ok_i) && $past(core_ok_i))) else $error("armed without supplies"); // R7

endmodule

// File: rtl/can_phy_ctrl.sv
module can_phy_ctrl
  import can_phy_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TMO_NS  = 1_250_000,
  parameter int unsigned WAKE_NS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic txd_i,
  input  logic hs_dom_i,
  input  logic lp_dom_i,
  input  logic core_ok_i,
  input  logic io_ok_i,
  input  logic ot_i,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic rxd_o,
  output logic split_en_o
);

  localparam int unsigned TMO_RAW  = ns_to_cyc(64'(CLK_HZ), 64'(TMO_NS));
  localparam int unsigned WAKE_RAW = ns_to_cyc(64'(CLK_HZ), 64'(WAKE_NS));
  localparam int unsigned TMO_CYC  = (TMO_RAW  < 2) ? 2 : TMO_RAW;
  localparam int unsigned WAKE_CYC = (WAKE_RAW < 1) ? 1 : WAKE_RAW;

  // Safe reset levels: standby, recessive transmit, everything else idle.
  localparam logic [SI_NUM-1:0] SYNC_RST = 7'b000_0011;

  logic [SI_NUM-1:0] raw_in;
  logic [SI_NUM-1:0] sync_in;

  assign raw_in[SI_MODE] = mode_i;
  assign raw_in[SI_TXD]  = txd_i;
  assign raw_in[SI_HS]   = hs_dom_i;
  assign raw_in[SI_LP]   = lp_dom_i;
  assign raw_in[SI_CORE] = core_ok_i;
  assign raw_in[SI_IO]   = io_ok_i;
  assign raw_in[SI_OT]   = ot_i;

  sync_bank #(
    .W       (SI_NUM),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  phy_mode_e mode_s;
  logic      txd_s;
  logic      hs_s;
  logic      lp_s;
  logic      core_s;
  logic      io_s;
  logic      ot_s;

  assign mode_s = phy_mode_e'(sync_in[SI_MODE]);
  assign txd_s  = sync_in[SI_TXD];
  assign hs_s   = sync_in[SI_HS];
  assign lp_s   = sync_in[SI_LP];
  assign core_s = sync_in[SI_CORE];
  assign io_s   = sync_in[SI_IO];
  assign ot_s   = sync_in[SI_OT];

  logic is_norm;
  logic armed;
  logic lp_live;

  assign is_norm = (mode_s == MODE_NORMAL);

  supply_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_ok_i (core_s),
    .io_ok_i   (io_s),
    .armed_o   (armed)
  );

  assign lp_live = !is_norm && armed;

  // Stuck-low transmit watchdog, Normal mode only.
  logic tx_trip;

  dom_counter #(.LIMIT(TMO_CYC)) u_tx_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (is_norm),
    .level_i  (!txd_s),
    .hit_o    (tx_trip)
  );

  // Stuck-dominant bus watchdog, Standby mode only.
  logic bus_trip;

  dom_counter #(.LIMIT(TMO_CYC)) u_bus_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (lp_live),
    .level_i  (lp_s),
    .hit_o    (bus_trip)
  );

  // Wake-up filter: minimum dominant time before reporting.
  logic wake_dom;

  dom_counter #(.LIMIT(WAKE_CYC)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (lp_live),
    .level_i  (lp_s),
    .hit_o    (wake_dom)
  );

  logic drv_ok;
  logic rx_norm;
  logic rx_stby;

  always_comb begin
    drv_ok  = is_norm && armed && core_s && !ot_s && !tx_trip;
    rx_norm = !(core_s && hs_s);
    rx_stby = !(armed && wake_dom && !bus_trip);
  end

  assign drv_en_o   = drv_ok;
  assign drv_dom_o  = drv_ok && !txd_s;
  assign rxd_o      = is_norm ? rx_norm : rx_stby;
  assign split_en_o = is_norm && core_s;

  AST_STBY_NO_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    !is_norm |-> !drv_en_o) else $error("driver on in standby"); // R4

  AST_DOM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom_o |-> drv_en_o) else $error("dominant without enable"); // R2

  AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |-> !drv_en_o) else $error("driver on while hot"); // R8

  AST_TX_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_trip && !txd_s) |-> !drv_dom_o) else $error("stuck transmit still driving"); // R5

  AST_BUS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_norm && bus_trip) |-> rxd_o) else $error("stuck bus not masked"); // R6

  AST_CORE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (is_norm && !core_s) |-> (rxd_o && !drv_en_o)) else $error("core loss not handled"); // R3

endmodule

// File: tb/can_phy_ctrl_tb.sv
`timescale 1ns/1ps
module can_phy_ctrl_tb;

  localparam int CLK_HZ  = 50_000_000;
  localparam int TMO_NS  = 400;
  localparam int WAKE_NS = 100;
  localparam int TMO  = (CLK_HZ / 1_000_000) * TMO_NS / 1000;
  localparam int WAKE = (CLK_HZ / 1_000_000) * WAKE_NS / 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic mode, txd, hs, lp, core, io, ot;
  logic drv_en, drv_dom, rxd, split_en;

  int total = 0;
  int bad   = 0;
  logic mon_on = 1'b0;
  logic seen_low;

  always #10 clk = ~clk;

  can_phy_ctrl #(
    .CLK_HZ  (CLK_HZ),
    .TMO_NS  (TMO_NS),
    .WAKE_NS (WAKE_NS)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .txd_i      (txd),
    .hs_dom_i   (hs),
    .lp_dom_i   (lp),
    .core_ok_i  (core),
    .io_ok_i    (io),
    .ot_i       (ot),
    .drv_en_o   (drv_en),
    .drv_dom_o  (drv_dom),
    .rxd_o      (rxd),
    .split_en_o (split_en)
  );

  always @(negedge clk) if (mon_on && !rxd) seen_low = 1'b1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 1'b1; txd = 1'b1; hs = 1'b0; lp = 1'b0;
    core = 1'b0; io = 1'b0; ot = 1'b0;
    step(3);
    chk("R1 drv_en", drv_en, 1'b0);
    chk("R1 drv_dom", drv_dom, 1'b0);
    chk("R1 rxd", rxd, 1'b1);
    chk("R1 split", split_en, 1'b0);
    rst_n = 1'b1;

    // R7: unarmed standby ignores the bus
    lp = 1'b1; step(12);
    chk("R7 unarmed standby rxd", rxd, 1'b1);
    lp = 1'b0;

    // R7: arming sequence
    mode = 1'b0; core = 1'b1; step(4);
    chk("R7 core only drv_en", drv_en, 1'b0);
    chk("R9 normal core split", split_en, 1'b1);
    io = 1'b1; step(3);
    chk("R7 armed drv_en", drv_en, 1'b1);
    io = 1'b0; step(4);
    chk("R7 io drop keeps drv_en", drv_en, 1'b1);
    hs = 1'b1; step(2);
    chk("R3 dominant rxd", rxd, 1'b0);
    core = 1'b0; step(2);
    chk("R3 core loss rxd", rxd, 1'b1);
    chk("R7 core loss drv_en", drv_en, 1'b0);
    chk("R9 core loss split", split_en, 1'b0);
    core = 1'b1; step(4);
    chk("R7 not rearmed drv_en", drv_en, 1'b0);
    io = 1'b1; step(3);
    chk("R7 rearmed drv_en", drv_en, 1'b1);
    hs = 1'b0; step(2);

    // R2 / R3 sweeps
    for (int t = 0; t < 2; t++) begin
      txd = t[0]; step(2);
      chk("R2 drv_dom", drv_dom, ~t[0]);
      chk("R2 drv_en", drv_en, 1'b1);
    end
    txd = 1'b1; step(3);
    for (int h = 0; h < 2; h++) begin
      hs = h[0]; step(2);
      chk("R3 rxd follows", rxd, ~h[0]);
    end

    // R8
    ot = 1'b1; step(2);
    chk("R8 hot drv_en", drv_en, 1'b0);
    chk("R8 hot split", split_en, 1'b1);
    chk("R8 hot rxd", rxd, 1'b0);
    ot = 1'b0; step(2);
    chk("R8 cool drv_en", drv_en, 1'b1);
    hs = 1'b0; step(2);

    // R5 per-cycle walk through the timeout
    txd = 1'b0;
    for (int s = 1; s <= TMO + 4; s++) begin
      step(1);
      chk("R5 drv_en walk", drv_en, (s < TMO + 2));
      chk("R5 drv_dom walk", drv_dom, (s >= 2) && (s < TMO + 2));
    end
    txd = 1'b1; step(2);
    chk("R5 release dom", drv_dom, 1'b0);
    step(1);
    chk("R5 release drv_en", drv_en, 1'b1);

    // R10 normal-side timer clear
    txd = 1'b0; step(TMO + 4);
    chk("R10 tripped", drv_en, 1'b0);
    mode = 1'b1; step(4);
    mode = 1'b0;
    for (int s = 1; s <= TMO + 3; s++) begin
      step(1);
      chk("R10 restarted drv_en", drv_en, (s >= 2) && (s < TMO + 2));
    end
    txd = 1'b1; step(3);

    // R4 standby gating
    mode = 1'b1; hs = 1'b1; step(3);
    chk("R4 standby drv_en", drv_en, 1'b0);
    chk("R4 standby split", split_en, 1'b0);
    chk("R4 hs ignored rxd", rxd, 1'b1);
    hs = 1'b0;

    // R4 wake-up filter pulse sweep
    for (int p = 1; p <= WAKE + 1; p++) begin
      seen_low = 1'b0; mon_on = 1'b1;
      lp = 1'b1; step(p);
      lp = 1'b0; step(WAKE + 4);
      mon_on = 1'b0;
      chk("R4 wake pulse", seen_low, (p >= WAKE));
    end

    // R6 per-cycle walk through the bus timeout
    lp = 1'b1;
    for (int s = 1; s <= TMO + 4; s++) begin
      step(1);
      chk("R6 rxd walk", rxd, !((s - 2 >= WAKE) && (s - 2 < TMO)));
    end
    lp = 1'b0; step(3);
    chk("R6 recessive rxd", rxd, 1'b1);
    lp = 1'b1; step(WAKE + 2);
    chk("R6 wake rearmed", rxd, 1'b0);
    step(TMO);
    chk("R6 retrip", rxd, 1'b1);

    // R10 standby-side timer clear
    mode = 1'b0; step(4);
    mode = 1'b1;
    for (int s = 1; s <= WAKE + 3; s++) begin
      step(1);
      chk("R10 bus timer restarted", rxd, !((s >= 2) && (s - 2 >= WAKE)));
    end
    lp = 1'b0; step(3);

    // R9 sweep of mode x core
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 2; c++) begin
        mode = m[0]; core = c[0]; io = 1'b1; step(3);
        chk("R9 split sweep", split_en, !m[0] && c[0]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule